// File: doc/BRIEF.md
# Streaming NAND Page Parity Generator

This block builds a Hamming-style error-correcting code for one NAND flash page while the page's bytes stream past it, one byte in each cycle where the valid strobe is high. It keeps two kinds of parity. Column parity is taken from fixed subsets of the bits inside every byte. Row parity comes from sending the XOR of each whole byte to one of two accumulators, and one bit of the byte's position in the page picks which one. Each parity has a partner accumulator that collects the complementary set. A single flipped data bit therefore changes exactly one member of every pair. A later decoder uses this to find the faulty bit, and the same property lets two-bit errors be detected.

Software or the command sequencer pulses a clear at the start of every read or write command. The same clear also samples the page-size select, and the choice holds until the next clear. The block then counts the accepted bytes. It raises a done flag once the last byte of the selected page has been taken, and it ignores any further bytes until the next clear. The packed parity word is valid to read whenever done is high.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, parity_o is all zero, count_o is zero and done_o is low.
- R2: The column parities follow fixed bit subsets of each accepted byte, accumulated by XOR over the page. P1 takes bits 7,5,3,1 and P1' takes bits 6,4,2,0. P2 takes bits 7,6,3,2 and P2' takes bits 5,4,1,0. P4 takes bits 7,6,5,4 and P4' takes bits 3,2,1,0.
- R3: For each index bit i, the XOR of all eight bits of an accepted byte goes into row parity P(2^(i+3)) when bit i of that byte's page index is 1. When that bit is 0, it goes into P(2^(i+3))'.
- R4: size_sel_i is sampled only while clr_i is high. Its codes 0, 1, 2 and 3 select 512, 1024, 2048 and 4096 bytes, so the highest row parity is P2048, P4096, P8192 or P16384. Changing size_sel_i between clears has no effect.
- R5: Every parity_o bit above the selected page's highest row pair reads zero.
- R6: count_o holds the index of the next byte. It starts at 0 after a clear and goes up by one for each accepted byte. It does not change in cycles where valid_i is low.
- R7: done_o rises in the cycle after the byte with index page_size-1 is accepted. While done_o is high, bytes are ignored: parity_o and count_o do not change.
- R8: A clr_i pulse zeroes all parities, count_o and done_o in the next cycle. A byte presented in the same cycle as clr_i is dropped.
- R9: Flipping one data bit of a page changes exactly one member of every complementary pair (column pairs and active row pairs).
- R10: The parity_o layout is as follows. Bits 0 to 5 hold P1', P1, P2', P2, P4', P4. For i = 0 to 11, bit 6+2i holds P(2^(i+3))' and bit 7+2i holds P(2^(i+3)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Start-of-command clear; also samples size_sel_i |
| valid_i | input | 1 | data_i carries a page byte this cycle |
| data_i | input | 8 | Page byte |
| size_sel_i | input | 2 | Page size code (0:512, 1:1024, 2:2048, 3:4096) |
| parity_o | output | 30 | Packed column and row parity word |
| done_o | output | 1 | Whole page accepted |
| count_o | output | 13 | Bytes accepted since the last clear |

## Verification
Two events can land in the same cycle: a clear and an incoming byte. The bench provokes this by raising clr_i and valid_i together, with the byte all ones, in the middle of a page. The result is judged on the next cycle, where count, done and every parity must be zero. After that, a fresh run of bytes must give parities that match the reference model over those bytes alone. The bench also checks the boundary between the last byte and done, and the handling of bytes that arrive after the page has finished.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

   localparam int BYTE_W    = 8;
   localparam int COL_PAIRS = 3;

   // mask of byte bits whose position has bit k equal to hi
   function automatic logic [BYTE_W-1:0] col_mask(input int k, input logic hi);
      logic [BYTE_W-1:0] m;
      for (int b = 0; b < BYTE_W; b++) begin
         m[b] = (((b >> k) & 1) == 1) == hi;
      end
      return m;
   endfunction

endpackage

// File: rtl/necc_idx_ctl.sv
module necc_idx_ctl #(
   parameter int MIN_W = 9,
   parameter int SEL_W = 2,
   parameter int MAX_W = MIN_W + (1 << SEL_W) - 1,
   localparam int CNT_W = MAX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             valid,
   input  logic [SEL_W-1:0] size_sel,
   output logic             accept,
   output logic [MAX_W-1:0] idx,
   output logic [CNT_W-1:0] count,
   output logic             done,
   output logic [SEL_W-1:0] sel_q
);

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic [CNT_W-1:0] last_idx;

   assign last_idx = (CNT_W'(1) << (MIN_W + int'(sel_q))) - CNT_W'(1);
   assign accept   = valid && !done_q && !clr;
   assign idx      = cnt_q[MAX_W-1:0];
   assign count    = cnt_q;
   assign done     = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
         sel_q  <= '0;
      end else if (clr) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
         sel_q  <= size_sel;
      end else if (accept) begin
         cnt_q <= cnt_q + CNT_W'(1);
         if (cnt_q == last_idx) begin
            done_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/necc_col_acc.sv
module necc_col_acc
   import nand_ecc_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   accept,
   input  logic [BYTE_W-1:0]      data,
   output logic [2*COL_PAIRS-1:0] col
);

   for (genvar k = 0; k < COL_PAIRS; k++) begin : g_pair
      localparam logic [BYTE_W-1:0] HI_MASK = col_mask(k, 1'b1);
      localparam logic [BYTE_W-1:0] LO_MASK = col_mask(k, 1'b0);
      logic hi_q, lo_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
         end else if (clr) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
         end else if (accept) begin
            hi_q <= hi_q ^ (^(data & HI_MASK));
            lo_q <= lo_q ^ (^(data & LO_MASK));
         end
      end

      assign col[2*k]   = lo_q;
      assign col[2*k+1] = hi_q;
   end

endmodule

// File: rtl/necc_row_acc.sv
module necc_row_acc
   import nand_ecc_pkg::*;
#(
   parameter int PAIRS = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              accept,
   input  logic [PAIRS-1:0]  idx,
   input  logic [BYTE_W-1:0] data,
   output logic [PAIRS-1:0]  row_lo,
   output logic [PAIRS-1:0]  row_hi
);

   logic byte_par;
   assign byte_par = ^data;

   for (genvar i = 0; i < PAIRS; i++) begin : g_row
      logic hi_q, lo_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
         end else if (clr) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
         end else if (accept) begin
            if (idx[i]) hi_q <= hi_q ^ byte_par;
            else        lo_q <= lo_q ^ byte_par;
         end
      end

      assign row_hi[i] = hi_q;
      assign row_lo[i] = lo_q;
   end

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
   import nand_ecc_pkg::*;
#(
   parameter int MIN_IDX_BITS = 9,
   parameter int SEL_W        = 2,
   localparam int MAX_IDX_BITS = MIN_IDX_BITS + (1 << SEL_W) - 1,
   localparam int CNT_W        = MAX_IDX_BITS + 1,
   localparam int COL_W        = 2 * COL_PAIRS,
   localparam int PW           = COL_W + 2 * MAX_IDX_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              valid_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic [SEL_W-1:0]  size_sel_i,
   output logic [PW-1:0]     parity_o,
   output logic              done_o,
   output logic [CNT_W-1:0]  count_o
);

   if (MIN_IDX_BITS < 1) begin : g_bad_min
      $error("MIN_IDX_BITS must be at least 1");
   end
   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("SEL_W must lie in 1..3");
   end

   logic                    accept;
   logic [MAX_IDX_BITS-1:0] idx;
   logic [SEL_W-1:0]        sel_q;
   logic [COL_W-1:0]        col;
   logic [MAX_IDX_BITS-1:0] row_lo, row_hi;

   necc_idx_ctl #(.MIN_W(MIN_IDX_BITS), .SEL_W(SEL_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_i),
      .valid    (valid_i),
      .size_sel (size_sel_i),
      .accept   (accept),
      .idx      (idx),
      .count    (count_o),
      .done     (done_o),
      .sel_q    (sel_q)
   );

   necc_col_acc u_col (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_i),
      .accept (accept),
      .data   (data_i),
      .col    (col)
   );

   necc_row_acc #(.PAIRS(MAX_IDX_BITS)) u_row (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_i),
      .accept (accept),
      .idx    (idx),
      .data   (data_i),
      .row_lo (row_lo),
      .row_hi (row_hi)
   );

   assign parity_o[COL_W-1:0] = col;

   for (genvar i = 0; i < MAX_IDX_BITS; i++) begin : g_out
      if (i < MIN_IDX_BITS) begin : g_always
         assign parity_o[COL_W+2*i]   = row_lo[i];
         assign parity_o[COL_W+2*i+1] = row_hi[i];
      end else begin : g_masked
         logic en;
         assign en = i < (MIN_IDX_BITS + int'(sel_q));
         assign parity_o[COL_W+2*i]   = en & row_lo[i];
         assign parity_o[COL_W+2*i+1] = en & row_hi[i];
      end
   end

endmodule

// File: rtl/necc_chk.sv
module necc_chk #(
   parameter int PW    = 30,
   parameter int CNT_W = 13,
   parameter int MIN_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_i,
   input logic             valid_i,
   input logic [PW-1:0]    parity_o,
   input logic             done_o,
   input logic [CNT_W-1:0] count_o
);

   // R8
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (count_o == '0 && parity_o == '0 && !done_o));

   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !clr_i) |=> (done_o && $stable(parity_o) && $stable(count_o)));

   // R6
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i && !clr_i) |=> ($stable(count_o) && $stable(parity_o) && $stable(done_o)));

   // R6
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !clr_i && !done_o) |=> (count_o == $past(count_o) + 1'b1));

   // R7
   done_at_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($countones(count_o) == 1 && count_o >= (CNT_W'(1) << MIN_W)));

endmodule

bind nand_ecc_gen necc_chk #(.PW(PW), .CNT_W(CNT_W), .MIN_W(MIN_IDX_BITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr_i    (clr_i),
   .valid_i  (valid_i),
   .parity_o (parity_o),
   .done_o   (done_o),
   .count_o  (count_o)
);

// File: tb/nand_ecc_gen_tb.sv
module nand_ecc_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        valid = 1'b0;
   logic [7:0]  data = 8'h00;
   logic [1:0]  sel = 2'd0;
   logic [29:0] parity;
   logic        done;
   logic [12:0] count;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [7:0] mem [4096];

   always #2 clk = ~clk;

   nand_ecc_gen u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr),
      .valid_i    (valid),
      .data_i     (data),
      .size_sel_i (sel),
      .parity_o   (parity),
      .done_o     (done),
      .count_o    (count)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [29:0] ref_word(input int n, input int act);
      logic [29:0] w = '0;
      for (int j = 0; j < n; j++) begin
         for (int k = 0; k < 3; k++)
            for (int b = 0; b < 8; b++)
               if (((b >> k) & 1) == 1) w[2*k+1] ^= mem[j][b];
               else                     w[2*k]   ^= mem[j][b];
         for (int i = 0; i < act; i++)
            if (((j >> i) & 1) == 1) w[7+2*i] ^= ^mem[j];
            else                     w[6+2*i] ^= ^mem[j];
      end
      return w;
   endfunction

   task automatic fill();
      for (int j = 0; j < 4096; j++) mem[j] = 8'($urandom);
   endtask

   task automatic do_clear(input logic [1:0] s);
      @(negedge clk); clr = 1'b1; sel = s;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic send(input int n, input int start);
      for (int j = 0; j < n; j++) begin
         @(negedge clk); valid = 1'b1; data = mem[start+j];
      end
      @(negedge clk); valid = 1'b0;
   endtask

   task automatic t_reset();
      chk(parity == '0, "R1 parity", 32'(parity), 0);
      chk(count == '0, "R1 count", 32'(count), 0);
      chk(done == 1'b0, "R1 done", 32'(done), 0);
   endtask

   task automatic t_columns();
      for (int j = 0; j < 8; j++) mem[j] = 8'h00;
      mem[0] = 8'h80;
      do_clear(2'd0); send(1, 0);
      chk(parity[5:0] == 6'b101010, "R2 R10 col 0x80", 32'(parity[5:0]), 32'h2A);
      chk(parity[29:6] == 24'h015555, "R3 rows idx0", 32'(parity[29:6]), 32'h15555);
      mem[0] = 8'h01;
      do_clear(2'd0); send(1, 0);
      chk(parity[5:0] == 6'b010101, "R2 R10 col 0x01", 32'(parity[5:0]), 32'h15);
   endtask

   task automatic t_rows();
      for (int j = 0; j < 6; j++) mem[j] = 8'h00;
      mem[5] = 8'h01;
      do_clear(2'd0); send(6, 0);
      chk(parity[29:6] == 24'h015566, "R3 rows idx5", 32'(parity[29:6]), 32'h15566);
   endtask

   task automatic t_page(input logic [1:0] s);
      int n = 512 << s;
      int act = 9 + int'(s);
      logic [29:0] e;
      fill();
      do_clear(s);
      send(n - 1, 0);
      chk(done == 1'b0, "R7 done before last", 32'(done), 0);
      chk(count == 13'(n - 1), "R6 count before last", 32'(count), 32'(n - 1));
      send(1, n - 1);
      chk(done == 1'b1, "R7 done after last", 32'(done), 1);
      chk(count == 13'(n), "R6 count full page", 32'(count), 32'(n));
      e = ref_word(n, act);
      chk(parity == e, "R2 R3 R4 page parity", 32'(parity), 32'(e));
      chk((parity >> (6 + 2*act)) == '0, "R5 upper pairs zero", 32'(parity), 32'(e));
   endtask

   task automatic t_ignore();
      logic [29:0] p;
      logic [12:0] c;
      t_page(2'd0);
      p = parity; c = count;
      for (int j = 0; j < 5; j++) mem[600+j] = 8'hA5 ^ 8'(j);
      send(5, 600);
      chk(parity == p, "R7 ignored bytes parity", 32'(parity), 32'(p));
      chk(count == c, "R7 ignored bytes count", 32'(count), 32'(c));
   endtask

   task automatic t_sample();
      logic [29:0] e;
      fill();
      do_clear(2'd0);
      sel = 2'd3;
      send(512, 0);
      chk(done == 1'b1, "R4 size held at clear", 32'(done), 1);
      e = ref_word(512, 9);
      chk(parity == e, "R4 R5 parity with held size", 32'(parity), 32'(e));
   endtask

   task automatic t_collide();
      logic [29:0] e;
      fill();
      do_clear(2'd1);
      send(10, 0);
      @(negedge clk); clr = 1'b1; valid = 1'b1; data = 8'hFF; sel = 2'd1;
      @(negedge clk); clr = 1'b0; valid = 1'b0;
      chk(count == '0, "R8 count after clear", 32'(count), 0);
      chk(parity == '0, "R8 parity after clear", 32'(parity), 0);
      chk(done == 1'b0, "R8 done after clear", 32'(done), 0);
      send(20, 0);
      e = ref_word(20, 10);
      chk(parity == e, "R8 byte dropped at clear", 32'(parity), 32'(e));
      chk(count == 13'd20, "R8 R6 count after restart", 32'(count), 20);
   endtask

   task automatic t_flip();
      logic [29:0] w0, d;
      fill();
      do_clear(2'd0); send(512, 0);
      w0 = parity;
      mem[137][3] = ~mem[137][3];
      do_clear(2'd0); send(512, 0);
      d = w0 ^ parity;
      for (int p = 0; p < 12; p++)
         chk((d[2*p] ^ d[2*p+1]) == 1'b1, "R9 one member per pair", 32'(d), 32'(p));
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #800000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_columns();
      t_rows();
      for (int s = 0; s < 4; s++) t_page(2'(s));
      t_ignore();
      t_sample();
      t_collide();
      t_flip();
      summary();
   end

endmodule